// File: doc/BRIEF.md
# Ethernet Receive Destination Filter

This block decides whether a received Ethernet frame is kept. It watches the byte stream of a frame from its first byte and gathers the 48-bit destination address. The address is tested against several sources at once: a bank of programmable exact-match slots, each with its own enable; a 64-entry hash table indexed by a folded form of the address; the all-ones broadcast address, which is subject to an enable; and a promiscuous copy-all mode. A separate early-match input from outside logic can also cause the frame to be kept, but only while the frame is still short.

For each frame the block gives one decision pulse. The pulse carries a keep or drop flag and a reason vector with one bit per source. Receive logic stores this vector with the frame's descriptor. Several reason bits can be set together. Frame storage, CRC checking and DMA belong to other blocks. The configuration inputs are expected to stay stable while a frame is being received.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset `dec_valid` is low, and no decision is given until the bytes of a frame have been counted.
- R2: The first received byte of a frame fills address bits [7:0] and the sixth fills bits [47:40]. Slot i (0..3) matches when its enable `sa_en[i]` is set and its 48-bit field `sa_addr[48*i+47:48*i]` equals the address. It reports reason bit i.
- R3: A slot whose enable bit is clear never matches, even when its address is equal.
- R4: Hash index bit j (0..5) is the XOR of address bits j, j+6, j+12, …, j+42. The frame matches when `hash_tbl[index]` is 1. This reports reason bit 4.
- R5: The address 0xFFFFFFFFFFFF reports reason bit 5, and only when `bcast_en` is 1.
- R6: When `copy_all` is 1 every frame is kept with reason bit 6.
- R7: When any address-based source matches, `dec_valid` is high for exactly the one cycle after the clock edge that takes in the sixth byte. `dec_accept` is 1, and `dec_reason` has every matching bit set. `dec_reason` is zero whenever `dec_accept` is 0.
- R8: `ext_match` counts only in a cycle where fewer than 16 bytes (four 32-bit words) of the frame were taken before that cycle. When it counts, it sets reason bit 7 and keeps the frame. If no address source matched and the sixth byte is already in, the decision comes in the cycle after the `ext_match` cycle. If `ext_match` came earlier, the decision comes in the cycle after the sixth byte.
- R9: `ext_match` at or after the 16-byte deadline is ignored. A frame with no match gets one drop decision (`dec_accept` 0, `dec_reason` 0) in the cycle after the edge that takes in its 16th byte.
- R10: There is at most one decision per frame. `sof` together with a byte starts a new frame and discards the state of the frame before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof | input | 1 | First byte of a new frame is on `byte_data` |
| byte_valid | input | 1 | `byte_data` carries a received byte this cycle |
| byte_data | input | 8 | Received byte |
| ext_match | input | 1 | Early address match from outside logic |
| sa_addr | input | 192 | Four 48-bit exact-match addresses, slot i at bits 48*i+47:48*i |
| sa_en | input | 4 | Enable per exact-match slot |
| hash_tbl | input | 64 | Hash match table |
| bcast_en | input | 1 | Allow broadcast frames |
| copy_all | input | 1 | Keep every frame |
| dec_valid | output | 1 | One-cycle decision pulse |
| dec_accept | output | 1 | Frame is kept (valid with `dec_valid`) |
| dec_reason | output | 8 | Match reasons: 0-3 slots, 4 hash, 5 broadcast, 6 copy-all, 7 external |

## Verification
The hardest corner to reach from the ports is the edge of the early-match window. An `ext_match` pulse in the cycle that brings in the 16th byte must still keep the frame. A pulse one cycle later must lose out to the drop decision. Idle gaps between bytes move that boundary away from any fixed cycle number. Directed frames put the pulse on the last counting cycle, the first cycle past it, and inside the address bytes before any address match exists. Random frames with gaps and random pulse positions then test the same boundary against a per-cycle model.

// File: rtl/rx_addr_filter_pkg.sv
package rx_addr_filter_pkg;
   // Reason-vector offsets above the exact-match slot bits
   localparam int RSN_OFS_HASH  = 0;
   localparam int RSN_OFS_BCAST = 1;
   localparam int RSN_OFS_COPY  = 2;
   localparam int RSN_OFS_EXT   = 3;
   localparam int RSN_EXTRA     = 4;
endpackage

// File: rtl/rx_addr_capture.sv
module rx_addr_capture #(
   parameter int ADDR_W     = 48,
   parameter int DL_BYTES   = 16,
   parameter int CNT_W      = $clog2(DL_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sof,
   input  logic              byte_valid,
   input  logic [7:0]        byte_data,
   input  logic              ext_match,
   output logic [ADDR_W-1:0] da_q,
   output logic [CNT_W-1:0]  cnt_q,
   output logic              ext_q
);
   localparam int ADDR_BYTES = ADDR_W / 8;
   localparam logic [CNT_W-1:0] DL_C = CNT_W'(DL_BYTES);

   logic [CNT_W-1:0] base;
   logic             in_window;

   assign base      = sof ? '0 : cnt_q;
   assign in_window = (base < DL_C);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         da_q  <= '0;
         cnt_q <= '0;
         ext_q <= 1'b0;
      end else begin
         if (byte_valid) begin
            if (int'(base) < ADDR_BYTES)
               da_q[int'(base)*8 +: 8] <= byte_data;
            cnt_q <= (base == DL_C) ? DL_C : base + 1'b1;
         end else begin
            cnt_q <= base;
         end
         ext_q <= (sof ? 1'b0 : ext_q) | (ext_match & in_window);
      end
   end

   // Counter never passes the deadline
   p_cnt_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= DL_C);

   // Once past the deadline the early-match flag is frozen until a new frame
   p_ext_late_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == DL_C && !sof) |=> (ext_q == $past(ext_q)));
endmodule

// File: rtl/rx_addr_match.sv
module rx_addr_match
   import rx_addr_filter_pkg::*;
#(
   parameter int N_SA     = 4,
   parameter int ADDR_W   = 48,
   parameter int HASH_W   = 6,
   parameter bit USE_HASH = 1'b1,
   parameter int HIT_W    = N_SA + RSN_EXTRA - 1
) (
   input  logic [ADDR_W-1:0]      da,
   input  logic [N_SA*ADDR_W-1:0] sa_addr,
   input  logic [N_SA-1:0]        sa_en,
   input  logic [2**HASH_W-1:0]   hash_tbl,
   input  logic                   bcast_en,
   input  logic                   copy_all,
   output logic [HIT_W-1:0]       hits
);
   genvar gi;
   generate
      for (gi = 0; gi < N_SA; gi++) begin : g_slot
         assign hits[gi] = sa_en[gi] && (da == sa_addr[gi*ADDR_W +: ADDR_W]);
      end

      if (USE_HASH) begin : g_hash
         logic [HASH_W-1:0] idx;
         always_comb begin
            idx = '0;
            for (int i = 0; i < ADDR_W; i++)
               idx[i % HASH_W] = idx[i % HASH_W] ^ da[i];
         end
         assign hits[N_SA + RSN_OFS_HASH] = hash_tbl[idx];
      end else begin : g_no_hash
         assign hits[N_SA + RSN_OFS_HASH] = 1'b0;
      end
   endgenerate

   assign hits[N_SA + RSN_OFS_BCAST] = bcast_en && (&da);
   assign hits[N_SA + RSN_OFS_COPY]  = copy_all;
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
   import rx_addr_filter_pkg::*;
#(
   parameter int N_SA        = 4,
   parameter int ADDR_W      = 48,
   parameter int HASH_W      = 6,
   parameter bit USE_HASH    = 1'b1,
   parameter int WORD_LIMIT  = 4,
   parameter int WORD_BYTES  = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      sof,
   input  logic                      byte_valid,
   input  logic [7:0]                byte_data,
   input  logic                      ext_match,
   input  logic [N_SA*ADDR_W-1:0]    sa_addr,
   input  logic [N_SA-1:0]           sa_en,
   input  logic [2**HASH_W-1:0]      hash_tbl,
   input  logic                      bcast_en,
   input  logic                      copy_all,
   output logic                      dec_valid,
   output logic                      dec_accept,
   output logic [N_SA+RSN_EXTRA-1:0] dec_reason
);
   localparam int ADDR_BYTES = ADDR_W / 8;
   localparam int DL_BYTES   = WORD_LIMIT * WORD_BYTES;
   localparam int CNT_W      = $clog2(DL_BYTES + 1);
   localparam int HIT_W      = N_SA + RSN_EXTRA - 1;
   localparam logic [CNT_W-1:0] DL_C   = CNT_W'(DL_BYTES);
   localparam logic [CNT_W-1:0] ADDR_C = CNT_W'(ADDR_BYTES);

   generate
      if (ADDR_W % 8 != 0) begin : g_chk_bytes
         $error("ADDR_W must be a whole number of bytes");
      end
      if (DL_BYTES < ADDR_BYTES) begin : g_chk_window
         $error("early-match window must cover the address");
      end
      if (N_SA < 1 || HASH_W < 1 || HASH_W > ADDR_W) begin : g_chk_sizes
         $error("bad slot count or hash width");
      end
   endgenerate

   logic [ADDR_W-1:0] da_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              ext_q;
   logic [HIT_W-1:0]  hits;
   logic              done_q;
   logic              any_hit, addr_ok, at_dl;

   rx_addr_capture #(
      .ADDR_W   (ADDR_W),
      .DL_BYTES (DL_BYTES),
      .CNT_W    (CNT_W)
   ) u_capture (
      .clk        (clk),
      .rst_n      (rst_n),
      .sof        (sof),
      .byte_valid (byte_valid),
      .byte_data  (byte_data),
      .ext_match  (ext_match),
      .da_q       (da_q),
      .cnt_q      (cnt_q),
      .ext_q      (ext_q)
   );

   rx_addr_match #(
      .N_SA     (N_SA),
      .ADDR_W   (ADDR_W),
      .HASH_W   (HASH_W),
      .USE_HASH (USE_HASH),
      .HIT_W    (HIT_W)
   ) u_match (
      .da       (da_q),
      .sa_addr  (sa_addr),
      .sa_en    (sa_en),
      .hash_tbl (hash_tbl),
      .bcast_en (bcast_en),
      .copy_all (copy_all),
      .hits     (hits)
   );

   assign addr_ok    = (cnt_q >= ADDR_C);
   assign at_dl      = (cnt_q == DL_C);
   assign any_hit    = (|hits) | ext_q;
   assign dec_valid  = !done_q && ((addr_ok && any_hit) || at_dl);
   assign dec_accept = dec_valid && any_hit;
   assign dec_reason = dec_accept ? {ext_q, hits} : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   done_q <= 1'b0;
      else if (sof) done_q <= 1'b0;
      else          done_q <= done_q | dec_valid;
   end

   // R7: no decision before the whole address is in
   p_addr_complete_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> (cnt_q >= ADDR_C));

   // R9: a drop is only issued at the deadline
   p_reject_at_deadline_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !dec_accept) |-> (cnt_q == DL_C && dec_reason == '0));

   // R10: a decision pulse never lasts two cycles
   p_single_decision_r10: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |=> !dec_valid);

   // R5: broadcast reason requires the enable
   p_bcast_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dec_reason[N_SA + RSN_OFS_BCAST] |-> bcast_en);

   // R6: copy-all reason requires the mode
   p_copy_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dec_reason[N_SA + RSN_OFS_COPY] |-> copy_all);

   genvar ga;
   generate
      for (ga = 0; ga < N_SA; ga++) begin : g_sa_chk
         // R3: a disabled slot never appears in the reason
         p_disabled_sa_r3: assert property (@(posedge clk) disable iff (!rst_n)
            dec_reason[ga] |-> sa_en[ga]);
      end
   endgenerate
endmodule

// File: tb/rx_addr_filter_bench.sv
module rx_addr_filter_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DL = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         sof = 1'b0, byte_valid = 1'b0, ext_match = 1'b0;
   logic [7:0]   byte_data = '0;
   logic [191:0] sa_addr = '0;
   logic [3:0]   sa_en = '0;
   logic [63:0]  hash_tbl = '0;
   logic         bcast_en = 1'b0, copy_all = 1'b0;
   logic         dec_valid, dec_accept;
   logic [7:0]   dec_reason;

   always #(CLK_PERIOD/2) clk = ~clk;

   rx_addr_filter u_rx_addr_filter (
      .clk(clk), .rst_n(rst_n), .sof(sof), .byte_valid(byte_valid),
      .byte_data(byte_data), .ext_match(ext_match), .sa_addr(sa_addr),
      .sa_en(sa_en), .hash_tbl(hash_tbl), .bcast_en(bcast_en),
      .copy_all(copy_all), .dec_valid(dec_valid), .dec_accept(dec_accept),
      .dec_reason(dec_reason)
   );

   int n_chk = 0, n_fail = 0;
   int m_cnt = 0;
   logic [47:0] m_da = '0;
   bit m_ext = 0, m_done = 0;
   int cur_c, obs_n, obs_cyc;
   logic [8:0] obs_dec;

   function automatic logic [5:0] fold(input logic [47:0] a);
      logic [5:0] r = '0;
      for (int k = 0; k < 8; k++) r ^= a[6*k +: 6];
      return r;
   endfunction

   function automatic logic [6:0] exp_hits(input logic [47:0] a);
      logic [6:0] h;
      for (int i = 0; i < 4; i++) h[i] = sa_en[i] && (a == sa_addr[48*i +: 48]);
      h[4] = hash_tbl[fold(a)];
      h[5] = bcast_en && (a == 48'hFFFF_FFFF_FFFF);
      h[6] = copy_all;
      return h;
   endfunction

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic cyc(input bit s, input bit v, input logic [7:0] b, input bit e);
      logic [6:0] h;
      bit any, fire, acc;
      logic [7:0] rsn, diff;
      string tag;
      int base;
      @(negedge clk);
      h    = exp_hits(m_da);
      any  = (|h) || m_ext;
      fire = !m_done && ((m_cnt >= 6 && any) || m_cnt == DL);
      acc  = fire && any;
      rsn  = acc ? {m_ext, h} : 8'h00;
      if (!fire) tag = "R10";
      else if (!acc) tag = "R9";
      else if (h == 0) tag = "R8";
      else tag = "R7";
      check(dec_valid == fire, tag, "dec_valid", 32'(dec_valid), 32'(fire));
      if (fire && dec_valid) begin
         diff = dec_reason ^ rsn;
         if (diff[7]) tag = "R8";
         else if (diff[6]) tag = "R6";
         else if (diff[5]) tag = "R5";
         else if (diff[4]) tag = "R4";
         else if (diff[3:0] != 0) tag = "R2";
         check({dec_accept, dec_reason} == {acc, rsn}, tag, "accept/reason",
               32'({dec_accept, dec_reason}), 32'({acc, rsn}));
      end
      if (dec_valid) begin
         obs_n++;
         obs_cyc = cur_c;
         obs_dec = {dec_accept, dec_reason};
      end
      sof = s; byte_valid = v; byte_data = b; ext_match = e;
      @(posedge clk);
      base   = s ? 0 : m_cnt;
      m_ext  = (s ? 1'b0 : m_ext) | (e && base < DL);
      if (v && base < 6) m_da[8*base +: 8] = b;
      m_cnt  = v ? ((base == DL) ? DL : base + 1) : base;
      m_done = s ? 1'b0 : (m_done | fire);
   endtask

   task automatic run_frame(input logic [47:0] da, input int len, input int ext_at,
                            input bit gaps, input int idle);
      int i = 0;
      int c = 0;
      bit v;
      logic [7:0] b;
      obs_n = 0;
      while (i < len) begin
         v = (c == 0) || !gaps || ($urandom_range(0, 3) != 0);
         b = (i < 6) ? da[8*i +: 8] : 8'($urandom);
         cur_c = c;
         cyc(c == 0, v, b, c == ext_at);
         if (v) i++;
         c++;
      end
      for (int k = 0; k < idle; k++) begin
         cur_c = c;
         cyc(1'b0, 1'b0, 8'h00, c == ext_at);
         c++;
      end
   endtask

   task automatic expect_dec(input string tag, input int n, input int c, input logic [8:0] d);
      check(obs_n == n && (n == 0 || (obs_cyc == c && obs_dec == d)), tag, "decision {n,cycle,acc,reason}",
            {8'(obs_n), 8'(obs_cyc), 7'h0, obs_dec}, {8'(n), 8'(c), 7'h0, d});
   endtask

   task automatic clear_cfg;
      sa_en = '0; hash_tbl = '0; bcast_en = 0; copy_all = 0; sa_addr = '0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      logic [47:0] a, b2;
      void'($urandom(32'd2718));
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      check(dec_valid == 1'b0, "R1", "dec_valid after reset", 32'(dec_valid), 0);
      rst_n = 1'b1;
      for (int k = 0; k < 4; k++) begin cur_c = k; cyc(0, 0, 8'h00, k == 1); end
      @(negedge clk);
      check(dec_valid == 1'b0, "R1", "no decision without bytes", 32'(dec_valid), 0);

      // R2: enabled slot 1 matches, decision at cycle 6
      clear_cfg();
      a = 48'h0A0B_0C0D_0E0F;
      sa_addr[48 +: 48] = a; sa_en = 4'b0010;
      run_frame(a, 20, -1, 0, 2);
      expect_dec("R2", 1, 6, 9'h102);
      // R3: same address, slot disabled -> drop at cycle 16
      sa_en = 4'b0000;
      run_frame(a, 20, -1, 0, 2);
      expect_dec("R3", 1, 16, 9'h000);
      // R4: hash hit and miss
      clear_cfg();
      a = 48'h1234_5678_9ABC;
      hash_tbl = 64'(1) << fold(a);
      run_frame(a, 20, -1, 0, 2);
      expect_dec("R4", 1, 6, 9'h110);
      hash_tbl = ~(64'(1) << fold(a));
      run_frame(a, 20, -1, 0, 2);
      expect_dec("R4", 1, 16, 9'h000);
      // R5: broadcast gated
      clear_cfg();
      run_frame(48'hFFFF_FFFF_FFFF, 20, -1, 0, 2);
      expect_dec("R5", 1, 16, 9'h000);
      bcast_en = 1;
      run_frame(48'hFFFF_FFFF_FFFF, 20, -1, 0, 2);
      expect_dec("R5", 1, 6, 9'h120);
      // R7: several reasons at once (slot 0 + broadcast)
      sa_addr[0 +: 48] = 48'hFFFF_FFFF_FFFF; sa_en = 4'b0001;
      run_frame(48'hFFFF_FFFF_FFFF, 20, -1, 0, 2);
      expect_dec("R7", 1, 6, 9'h121);
      // R6: copy-all
      clear_cfg(); copy_all = 1;
      run_frame(48'h0102_0304_0506, 20, -1, 0, 2);
      expect_dec("R6", 1, 6, 9'h140);
      // R8: external match early, mid-window, last counting cycle
      clear_cfg();
      a = 48'h5555_6666_7777;
      run_frame(a, 20, 2, 0, 2);
      expect_dec("R8", 1, 6, 9'h180);
      run_frame(a, 20, 12, 0, 2);
      expect_dec("R8", 1, 13, 9'h180);
      run_frame(a, 20, 15, 0, 2);
      expect_dec("R8", 1, 16, 9'h180);
      // R9: external match at or past deadline is ignored
      run_frame(a, 20, 16, 0, 2);
      expect_dec("R9", 1, 16, 9'h000);
      run_frame(a, 20, 18, 0, 3);
      expect_dec("R9", 1, 16, 9'h000);
      // R10: aborted frame then new frame; back-to-back frames
      b2 = 48'hAAAA_BBBB_CCCC;
      sa_addr[96 +: 48] = b2; sa_en = 4'b0100;
      run_frame(b2, 4, -1, 0, 0);
      expect_dec("R10", 0, 0, 9'h000);
      run_frame(b2, 20, -1, 0, 0);
      expect_dec("R10", 1, 6, 9'h104);
      run_frame(b2, 20, -1, 0, 2);
      expect_dec("R10", 1, 6, 9'h104);

      // Random frames with gaps, checked cycle by cycle
      for (int f = 0; f < 80; f++) begin
         int kind;
         for (int i = 0; i < 4; i++) sa_addr[48*i +: 48] = {$urandom, $urandom};
         sa_en    = 4'($urandom);
         hash_tbl = ($urandom_range(0, 1) != 0) ? {$urandom, $urandom} & {$urandom, $urandom} : '0;
         bcast_en = 1'($urandom);
         copy_all = ($urandom_range(0, 7) == 0);
         kind = $urandom_range(0, 3);
         case (kind)
            0: a = {$urandom, $urandom};
            1: a = sa_addr[48*$urandom_range(0, 3) +: 48];
            2: a = 48'hFFFF_FFFF_FFFF;
            default: begin a = {$urandom, $urandom}; hash_tbl[fold(a)] = 1'b1; end
         endcase
         run_frame(a, $urandom_range(16, 24), $urandom_range(0, 40),
                   1'($urandom), 2);
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule